// File: doc/BRIEF.md
# PHY Management Register Model

This block models the management side of an Ethernet PHY as seen by a host. The host writes one command word, which carries a PHY address, a register address, an opcode and an initiate flag, together with a 16-bit write value. The block holds a 32-entry, 16-bit register file for a single PHY at the address set by the `PHY_ADDR` parameter. An initiated write stores the value. An initiated read returns a value in a read-data register one cycle later, and a one-cycle completion pulse marks both kinds of command.

Several registers are not plain storage. The basic status, link partner ability, vendor speed and diagnostic registers are computed on each read from the advertisement register and from the `link_ok` level input. Every write also forces the soft-reset bit (bit 15) of the control register back to zero. A command aimed at any other PHY address finds no device: a read returns all ones and a write has no effect. The block does not model bit-serial management signalling or frame timing.

Top module: `phy_mgmt_model`

## Requirements
- R1: The command word is decoded as PHY address in bits 28:24, register address in bits 20:16, opcode in bits 15:14 and initiate in bit 11. Opcode 1 is a write and opcode 2 is a read.
- R2: `cmd_rd` returns the last command word written, with bit 7 always set as the ready flag. After reset it reads 0x00000080.
- R3: A read whose PHY address differs from `PHY_ADDR` returns 0xFFFF. A write to such an address changes no register.
- R4: After reset, register 0 reads 0x3100, register 2 reads 0x0300, register 3 reads 0xE400 and register 4 reads 0x01E1.
- R5: Register 1 reads 0x782E (bits 14, 13, 12, 11, 5, 3, 2 and 1) when `link_ok` is 1, and 0x0000 when `link_ok` is 0.
- R6: Register 5 reads 0x4001 ORed with bits 8:5 of register 4.
- R7: Register 17 always reads 0x8000, whatever the link state.
- R8: When `link_ok` is 1, register 18 has bit 10 set if register 4 bit 7 or bit 8 is set, and bit 11 set if register 4 bit 6 or bit 8 is set. All its other bits are zero. When `link_ok` is 0, register 18 reads zero.
- R9: An initiated write to the attached PHY stores `wdata` into the addressed register and then clears bit 15 of register 0. A later read of a plain register returns the stored value.
- R10: After `cmd_wr` with an initiated read or write, `done` is high for exactly the following cycle. On a read, `rdata` holds the result from that same cycle on.
- R11: A command with initiate clear, or with opcode 0 or 3, raises no `done` and leaves `rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Strobe that writes `cmd_word` into the command register |
| cmd_word | input | 32 | Command word (fields as in R1) |
| wdata | input | 16 | Write data for an initiated write |
| link_ok | input | 1 | Link flag used by the computed status registers |
| cmd_rd | output | 32 | Command register readback with the ready bit set |
| rdata | output | 16 | Result of the last initiated read |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest cases to reach are the values computed from stored state. Registers 5 and 18 only show a change once register 4 has been rewritten. The soft-reset clear only shows when a written bit 15 reads back as zero. The stimulus therefore writes register 4 with the 10 Mb full-duplex pattern and then the 100 Mb half-duplex pattern, and rereads both computed registers after each write. A write to an absent PHY is checked by rereading a register that it would otherwise have overwritten. The link-down view is checked by dropping `link_ok` only after the table has run.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 5;
    localparam int NREGS   = 1 << ADDR_W;
    localparam int CMD_W   = 32;

    localparam logic [CMD_W-1:0] READY_MASK = 32'h0000_0080;

    localparam logic [ADDR_W-1:0] RA_CTRL = 5'd0;
    localparam logic [ADDR_W-1:0] RA_STAT = 5'd1;
    localparam logic [ADDR_W-1:0] RA_ADV  = 5'd4;
    localparam logic [ADDR_W-1:0] RA_LPA  = 5'd5;
    localparam logic [ADDR_W-1:0] RA_SPD  = 5'd17;
    localparam logic [ADDR_W-1:0] RA_DIAG = 5'd18;

    typedef enum logic [1:0] {
        OP_NOP0  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_NOP3  = 2'd3
    } mgmt_op_e;

    typedef struct packed {
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        mgmt_op_e          op;
        logic              go;
    } mgmt_cmd_t;

    function automatic mgmt_cmd_t unpack_cmd(input logic [CMD_W-1:0] w);
        mgmt_cmd_t c;
        c.phy   = w[28:24];
        c.regad = w[20:16];
        c.op    = mgmt_op_e'(w[15:14]);
        c.go    = w[11];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] reset_value(input int idx);
        case (idx)
            0:       return 16'h3100;
            2:       return 16'h0300;
            3:       return 16'hE400;
            4:       return 16'h01E1;
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/mgmt_cmd_decode.sv
module mgmt_cmd_decode
    import phy_mgmt_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PHY_ADDR = 5'd7
) (
    input  logic                cmd_wr,
    input  logic [CMD_W-1:0]    cmd_word,
    output logic [ADDR_W-1:0]   regad,
    output logic                hit,
    output logic                rd_fire,
    output logic                wr_fire
);
    mgmt_cmd_t c;

    always_comb begin
        c       = unpack_cmd(cmd_word);
        regad   = c.regad;
        hit     = (c.phy == PHY_ADDR);
        rd_fire = cmd_wr && c.go && (c.op == OP_READ);
        wr_fire = cmd_wr && c.go && (c.op == OP_WRITE);
    end
endmodule

// File: rtl/phy_reg_bank.sv
module phy_reg_bank
    import phy_mgmt_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [DATA_W-1:0]               wr_data,
    output logic [NREGS-1:0][DATA_W-1:0]    regs
);
    logic [NREGS-1:0][DATA_W-1:0] bank_d, bank_q;
    logic [NREGS-1:0][DATA_W-1:0] bank_init;

    for (genvar i = 0; i < NREGS; i++) begin : g_init
        assign bank_init[i] = reset_value(i);
    end

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            bank_d[wr_addr] = wr_data;
            bank_d[RA_CTRL][15] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= bank_init;
        else        bank_q <= bank_d;
    end

    assign regs = bank_q;

    // R9: a write never leaves the soft-reset bit set
    a_r9_reset_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> !bank_q[RA_CTRL][15]);
endmodule

// File: rtl/phy_status_view.sv
module phy_status_view
    import phy_mgmt_pkg::*;
(
    input  logic                            link_ok,
    input  logic [ADDR_W-1:0]               rd_addr,
    input  logic [NREGS-1:0][DATA_W-1:0]    regs,
    output logic [DATA_W-1:0]               rd_val
);
    logic [DATA_W-1:0] adv;
    logic              spd100, fdx;

    always_comb begin
        adv    = regs[RA_ADV];
        spd100 = adv[7] | adv[8];
        fdx    = adv[6] | adv[8];
        case (rd_addr)
            RA_STAT: rd_val = link_ok ? 16'h782E : 16'h0000;
            RA_LPA:  rd_val = 16'h4001 | (adv & 16'h01E0);
            RA_SPD:  rd_val = 16'h8000;
            RA_DIAG: rd_val = link_ok ? {4'b0, fdx, spd100, 10'b0} : 16'h0000;
            default: rd_val = regs[rd_addr];
        endcase
    end
endmodule

// File: rtl/phy_mgmt_model.sv
module phy_mgmt_model
    import phy_mgmt_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PHY_ADDR = 5'd7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_wr,
    input  logic [CMD_W-1:0]    cmd_word,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                link_ok,
    output logic [CMD_W-1:0]    cmd_rd,
    output logic [DATA_W-1:0]   rdata,
    output logic                done
);
    typedef struct packed {
        logic [CMD_W-1:0]  cmd;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } state_t;

    state_t st_d, st_q;

    logic [ADDR_W-1:0]              regad;
    logic                           hit, rd_fire, wr_fire;
    logic [NREGS-1:0][DATA_W-1:0]   regs;
    logic [DATA_W-1:0]              view_val;

    mgmt_cmd_decode #(.PHY_ADDR(PHY_ADDR)) u_dec (
        .cmd_wr   (cmd_wr),
        .cmd_word (cmd_word),
        .regad    (regad),
        .hit      (hit),
        .rd_fire  (rd_fire),
        .wr_fire  (wr_fire)
    );

    phy_reg_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_fire && hit),
        .wr_addr (regad),
        .wr_data (wdata),
        .regs    (regs)
    );

    phy_status_view u_view (
        .link_ok (link_ok),
        .rd_addr (regad),
        .regs    (regs),
        .rd_val  (view_val)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (cmd_wr) begin
            st_d.cmd = cmd_word;
            if (rd_fire) begin
                st_d.rdata = hit ? view_val : '1;
                st_d.done  = 1'b1;
            end
            if (wr_fire) st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_rd = st_q.cmd | READY_MASK;
    assign rdata  = st_q.rdata;
    assign done   = st_q.done;

    // R10: completion only follows an initiated read or write
    a_r10_done_follows_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(rd_fire || wr_fire));

    // R3: a read of an absent PHY yields all ones
    a_r3_absent_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_fire && !hit) |-> rdata == 16'hFFFF);

    // R11: read data moves only on an initiated read
    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_fire) |-> $stable(rdata));

    // R5: with the link down, basic status reads zero
    a_r5_link_down_status: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_fire && hit && !link_ok && regad == RA_STAT) |-> rdata == 16'h0000);
endmodule

// File: tb/phy_mgmt_model_tb.sv
module phy_mgmt_model_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_word = '0;
    logic [15:0] wdata = '0;
    logic        link_ok = 1'b1;
    logic [31:0] cmd_rd;
    logic [15:0] rdata;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    phy_mgmt_model #(.PHY_ADDR(5'd7)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .wdata(wdata), .link_ok(link_ok), .cmd_rd(cmd_rd), .rdata(rdata), .done(done)
    );

    typedef struct packed {
        logic [31:0] cmd;
        logic [15:0] wd;
        logic        exp_done;
        logic        chk_rd;
        logic [15:0] exp_rd;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{32'h0700_8800, 16'h0000, 1'b1, 1'b1, 16'h3100}, // R4 R1 reg0
        '{32'h0702_8800, 16'h0000, 1'b1, 1'b1, 16'h0300}, // R4 reg2
        '{32'h0703_8800, 16'h0000, 1'b1, 1'b1, 16'hE400}, // R4 reg3
        '{32'h0704_8800, 16'h0000, 1'b1, 1'b1, 16'h01E1}, // R4 reg4
        '{32'h0701_8800, 16'h0000, 1'b1, 1'b1, 16'h782E}, // R5 link up
        '{32'h0705_8800, 16'h0000, 1'b1, 1'b1, 16'h41E1}, // R6
        '{32'h0711_8800, 16'h0000, 1'b1, 1'b1, 16'h8000}, // R7
        '{32'h0712_8800, 16'h0000, 1'b1, 1'b1, 16'h0C00}, // R8 both
        '{32'h0704_4800, 16'h0040, 1'b1, 1'b0, 16'h0000}, // R9 write adv 10 full
        '{32'h0712_8800, 16'h0000, 1'b1, 1'b1, 16'h0800}, // R8 duplex only
        '{32'h0705_8800, 16'h0000, 1'b1, 1'b1, 16'h4041}, // R6
        '{32'h0704_4800, 16'h0080, 1'b1, 1'b0, 16'h0000}, // R9 write adv 100 half
        '{32'h0712_8800, 16'h0000, 1'b1, 1'b1, 16'h0400}, // R8 speed only
        '{32'h0705_8800, 16'h0000, 1'b1, 1'b1, 16'h4081}, // R6
        '{32'h0700_4800, 16'hB100, 1'b1, 1'b0, 16'h0000}, // R9 write ctrl with bit 15
        '{32'h0700_8800, 16'h0000, 1'b1, 1'b1, 16'h3100}, // R9 bit 15 cleared
        '{32'h0709_4800, 16'hABCD, 1'b1, 1'b0, 16'h0000}, // R9 plain write
        '{32'h0709_8800, 16'h0000, 1'b1, 1'b1, 16'hABCD}, // R9 readback
        '{32'h0309_8800, 16'h0000, 1'b1, 1'b1, 16'hFFFF}, // R3 absent read
        '{32'h0309_4800, 16'h1111, 1'b1, 1'b0, 16'h0000}, // R3 absent write
        '{32'h0709_8800, 16'h0000, 1'b1, 1'b1, 16'hABCD}, // R3 untouched
        '{32'h0709_C800, 16'h2222, 1'b0, 1'b1, 16'hABCD}, // R11 opcode 3
        '{32'h0709_0800, 16'h3333, 1'b0, 1'b1, 16'hABCD}, // R11 opcode 0
        '{32'h0709_8000, 16'h0000, 1'b0, 1'b1, 16'hABCD}  // R11 initiate clear
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at a falling edge, release at the next, then sample outputs
    task automatic issue(input logic [31:0] c, input logic [15:0] d);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_word = c; wdata = d;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 reset cmd_rd", cmd_rd, 32'h0000_0080);
        check("R10 reset done", {31'b0, done}, 32'h0);
        check("R11 reset rdata", {16'b0, rdata}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            issue(VEC[i].cmd, VEC[i].wd);
            check($sformatf("R10 done vec %0d", i), {31'b0, done}, {31'b0, VEC[i].exp_done});
            if (VEC[i].chk_rd)
                check($sformatf("R1 rdata vec %0d", i), {16'b0, rdata}, {16'b0, VEC[i].exp_rd});
            check($sformatf("R2 cmd_rd vec %0d", i), cmd_rd, VEC[i].cmd | 32'h80);
        end

        // R10: done lasts exactly one cycle
        issue(32'h0711_8800, 16'h0);
        @(negedge clk);
        check("R10 done single cycle", {31'b0, done}, 32'h0);
        check("R10 rdata held", {16'b0, rdata}, 32'h8000);

        // link down views
        link_ok = 1'b0;
        issue(32'h0701_8800, 16'h0);
        check("R5 link down status", {16'b0, rdata}, 32'h0);
        issue(32'h0712_8800, 16'h0);
        check("R8 link down diag", {16'b0, rdata}, 32'h0);
        issue(32'h0711_8800, 16'h0);
        check("R7 link down vendor", {16'b0, rdata}, 32'h8000);
        link_ok = 1'b1;
        issue(32'h0701_8800, 16'h0);
        check("R5 link restored", {16'b0, rdata}, 32'h782E);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule